// File: doc/BRIEF.md
# Integer ALU with Condition-Flag Evaluation

This block is the integer execution stage of a small 32-bit teaching processor. It takes two data operands and a two-bit function code, and in the same cycle it returns the sum, the difference, the bitwise AND or the bitwise XOR of them. When the decoder marks the operation as one that sets flags, the zero, sign and overflow outcome of that result is stored in a three-bit flag register on the next rising clock edge. Every other operation leaves the stored flags as they are.

A three-bit condition select is decoded against the stored flags. The result is one signal that tells the control logic whether a conditional jump is taken or a conditional register move is committed. The seven branch conditions and the six move conditions share this one evaluator: code 0 means "always" and is used only by jumps, and codes 1 to 6 serve both kinds of instruction.

Top module: `exu_alu_cc`

## Requirements
- R1: `result` is combinational and depends on `fn_sel`. Code 0 gives op_a + op_b, code 1 gives op_b − op_a, code 2 gives op_a & op_b and code 3 gives op_a ^ op_b. All arithmetic is modulo 2^32.
- R2: When `set_flags` is high at a rising edge and reset is not asserted, the flag outputs show the result of that cycle after the edge. `zf_o` is 1 if the result is zero, and `sf_o` is bit 31 of the result.
- R3: A flag update sets `of_o` when the signed 32-bit add or subtract overflows, that is, when the exact signed value lies outside the range −2^31 to 2^31−1. For AND and XOR a flag update clears `of_o`.
- R4: When `set_flags` is low at an edge, all three flags keep their values.
- R5: The reset is synchronous and active low. A clock edge with `rst_n` low sets zf=1, sf=0 and of=0, and this takes priority over `set_flags`.
- R6: Condition codes 1 to 6 are evaluated on the stored flags. Code 1 is less-or-equal, (sf^of)|zf. Code 2 is less, sf^of. Code 3 is equal, zf. Code 4 is not-equal, !zf. Code 5 is greater-or-equal, !(sf^of). Code 6 is greater, !(sf^of)&!zf.
- R7: Condition code 0 (always) gives `cond_true`=1 for any flags. Code 7 is unused and gives 0.
- R8: `cond_true` follows `cond_sel` and the stored flags in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | First operand (subtrahend for code 1) |
| op_b | input | 32 | Second operand (minuend for code 1) |
| fn_sel | input | 2 | Function code: 0 add, 1 sub, 2 and, 3 xor |
| set_flags | input | 1 | Store this cycle's flags at the edge |
| cond_sel | input | 3 | Condition code, 0 to 7 |
| result | output | 32 | Combinational result |
| zf_o | output | 1 | Stored zero flag |
| sf_o | output | 1 | Stored sign flag |
| of_o | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Selected condition holds |

## Verification
The clocked properties assume that `fn_sel`, the operands and `set_flags` are stable across each rising edge. They also assume that `rst_n` changes only between edges, so that the result sampled at an edge is the one that was stored. The bench drives every input on the falling edge and holds it through the next rising edge, so it stays within these assumptions. All eight condition codes are reachable under random stimulus, and code 7 is included on purpose. To drive the zero flag often, operands are forced equal from time to time, which gives zero from subtract and XOR.

// File: rtl/exu_pkg.sv
// Shared encodings for the integer execution unit.
// Assumes the function and condition codes of the instruction decoder.
package exu_pkg;
    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } fn_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_LE     = 3'd1,
        CC_LT     = 3'd2,
        CC_EQ     = 3'd3,
        CC_NE     = 3'd4,
        CC_GE     = 3'd5,
        CC_GT     = 3'd6,
        CC_NEVER  = 3'd7
    } cc_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic ovf;
    } flags_t;

    localparam flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, ovf: 1'b0};
endpackage

// File: rtl/exu_alu_core.sv
// Combinational datapath: add, subtract (B - A), AND, XOR, and the
// candidate flags for the result. One adder serves both add and subtract:
// A is inverted and the carry-in is raised for subtract.
// Assumes two's-complement operands of width W.
module exu_alu_core #(
    parameter int W = 32
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [1:0]      fn,
    output logic [W-1:0]    res,
    output exu_pkg::flags_t nxt
);
    import exu_pkg::*;

    localparam int MSB = W - 1;

    fn_e          fn_q;
    logic         is_sub;
    logic [W-1:0] a_adj;
    logic [W-1:0] sum;
    logic         arith_ovf;

    // Decode the function code and build the adder operand.
    always_comb begin
        fn_q   = fn_e'(fn);
        is_sub = (fn_q == FN_SUB);
        a_adj  = is_sub ? ~a : a;
    end

    // Shared adder for add and subtract.
    always_comb begin
        sum = b + a_adj + {{(W-1){1'b0}}, is_sub};
    end

    // Signed overflow: adder inputs share a sign that the sum does not.
    always_comb begin
        arith_ovf = (a_adj[MSB] == b[MSB]) && (sum[MSB] != b[MSB]);
    end

    // Result select and candidate flags.
    always_comb begin
        unique case (fn_q)
            FN_ADD, FN_SUB: res = sum;
            FN_AND:         res = a & b;
            default:        res = a ^ b;
        endcase
        nxt.zf  = (res == '0);
        nxt.sf  = res[MSB];
        nxt.ovf = (fn_q == FN_ADD || fn_q == FN_SUB) ? arith_ovf : 1'b0;
    end
endmodule

// File: rtl/exu_flag_reg.sv
// Three-bit flag register. It loads when enabled and holds otherwise.
// Assumes a synchronous active-low reset that wins over the load.
module exu_flag_reg (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  exu_pkg::flags_t d,
    output exu_pkg::flags_t q
);
    import exu_pkg::*;

    // Store the candidate flags on load, or the reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= FLAGS_RST;
        else if (load)
            q <= d;
    end

    a_r4_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q))
        else $error("R4 flags changed without load");

    a_r5_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q.zf && !q.sf && !q.ovf))
        else $error("R5 wrong flag reset value");
endmodule

// File: rtl/exu_cond_eval.sv
// Condition evaluator shared by conditional jumps and conditional moves.
// Assumes code 0 is used only by jumps and code 7 is never issued on purpose.
module exu_cond_eval (
    input  exu_pkg::flags_t flg,
    input  logic [2:0]      sel,
    output logic            taken
);
    import exu_pkg::*;

    logic lt;

    // Signed less-than from the sign and overflow flags.
    always_comb lt = flg.sf ^ flg.ovf;

    // Pick the condition.
    always_comb begin
        unique case (cc_e'(sel))
            CC_ALWAYS: taken = 1'b1;
            CC_LE:     taken = lt | flg.zf;
            CC_LT:     taken = lt;
            CC_EQ:     taken = flg.zf;
            CC_NE:     taken = ~flg.zf;
            CC_GE:     taken = ~lt;
            CC_GT:     taken = ~lt & ~flg.zf;
            default:   taken = 1'b0;
        endcase
    end

    always_comb begin
        if (sel == 3'd0)
            a_r7_always_taken: assert (taken) else $error("R7 always not taken");
    end
endmodule

// File: rtl/exu_alu_cc.sv
// Top of the integer execution unit. It produces a combinational result,
// keeps the registered flags and evaluates conditions on those flags.
// Assumes inputs are stable around each rising clock edge.
module exu_alu_cc #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        fn_sel,
    input  logic              set_flags,
    input  logic [2:0]        cond_sel,
    output logic [DATA_W-1:0] result,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o,
    output logic              cond_true
);
    import exu_pkg::*;

    flags_t flg_nxt;
    flags_t flg_q;

    exu_alu_core #(.W(DATA_W)) u_core (
        .a   (op_a),
        .b   (op_b),
        .fn  (fn_sel),
        .res (result),
        .nxt (flg_nxt)
    );

    exu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (set_flags),
        .d     (flg_nxt),
        .q     (flg_q)
    );

    exu_cond_eval u_cond (
        .flg   (flg_q),
        .sel   (cond_sel),
        .taken (cond_true)
    );

    // Drive the flag outputs from the register.
    always_comb begin
        zf_o = flg_q.zf;
        sf_o = flg_q.sf;
        of_o = flg_q.ovf;
    end

    a_r2_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (zf_o == ($past(result) == '0)) && (sf_o == $past(result[DATA_W-1])))
        else $error("R2 flags do not match stored result");

    a_r3_logic_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && fn_sel[1]) |=> !of_o)
        else $error("R3 overflow after logic op");
endmodule

// File: tb/exu_alu_cc_tb.sv
module exu_alu_cc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  fn_sel = '0;
    logic        set_flags = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic [31:0] result;
    logic        zf_o, sf_o, of_o, cond_true;

    int checks = 0;
    int errors = 0;

    // Reference state
    bit    m_zf = 1'b1, m_sf = 1'b0, m_of = 1'b0;
    string flag_tag = "R5";

    always #5 clk = ~clk;

    exu_alu_cc u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fn_sel(fn_sel),
        .set_flags(set_flags), .cond_sel(cond_sel), .result(result),
        .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .cond_true(cond_true)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] ref_result(bit [31:0] a, bit [31:0] b, int fn);
        case (fn)
            0: return a + b;
            1: return b - a;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic bit ref_ovf(bit [31:0] a, bit [31:0] b, int fn);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint v;
        if (fn == 0) v = sb + sa;
        else if (fn == 1) v = sb - sa;
        else return 1'b0;
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    function automatic bit ref_cond(int cs);
        bit lt = m_sf ^ m_of;
        case (cs)
            0: return 1'b1;
            1: return lt || m_zf;
            2: return lt;
            3: return m_zf;
            4: return !m_zf;
            5: return !lt;
            6: return !lt && !m_zf;
            default: return 1'b0;
        endcase
    endfunction

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(bit [31:0] a, bit [31:0] b, int fn, bit sf, int cs, bit rn = 1'b1);
        bit [31:0] r;
        @(negedge clk);
        op_a = a; op_b = b; fn_sel = 2'(fn); set_flags = sf; cond_sel = 3'(cs); rst_n = rn;
        #1;
        r = ref_result(a, b, fn);
        check(flag_tag, "zf", zf_o, m_zf);
        check(flag_tag, "sf", sf_o, m_sf);
        check(flag_tag, "of", of_o, m_of);
        check("R1", "result", result, r);
        check((cs == 0 || cs == 7) ? "R7" : "R6/R8", "cond_true", cond_true, ref_cond(cs));
        @(posedge clk);
        if (!rn) begin
            m_zf = 1; m_sf = 0; m_of = 0; flag_tag = "R5";
        end else if (sf) begin
            m_zf = (r == 0); m_sf = r[31]; m_of = ref_ovf(a, b, fn);
            flag_tag = (fn >= 2) ? "R3" : "R2/R3";
        end else begin
            flag_tag = "R4";
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R5 reset, with set_flags high to check that reset wins
        step(32'h1, 32'h1, 0, 1, 0, 0);
        step(32'h1, 32'h1, 0, 1, 3, 0);
        // R1/R2 zero from subtract, then R3 add overflow
        step(32'h5, 32'h5, 1, 1, 3);
        step(32'h1, 32'h7fffffff, 0, 1, 3);
        // R3 subtract overflow: 0x80000000 - 1
        step(32'h1, 32'h80000000, 1, 1, 2);
        // R4 hold while set_flags is low
        for (int c = 0; c < 8; c++) step(32'h0, 32'h0, 3, 0, c);
        // R3 logic op clears OF, negative result
        step(32'hffff0000, 32'hf0f0f0f0, 2, 1, 2);
        for (int c = 0; c < 8; c++) step(32'h12345678, 32'h12345678, 3, 0, c);
        // less: 3 - 5 negative without overflow
        step(32'h5, 32'h3, 1, 1, 1);
        for (int c = 0; c < 8; c++) step(32'h0, 32'h0, 0, 0, c);
        // greater: 5 - 3
        step(32'h3, 32'h5, 1, 1, 6);
        for (int c = 0; c < 8; c++) step(32'h0, 32'h0, 0, 0, c);
        // add wrap to zero: no signed overflow
        step(32'hffffffff, 32'h1, 0, 1, 3);
        step(32'h80000000, 32'h80000000, 0, 1, 3);
        for (int c = 0; c < 8; c++) step(32'h0, 32'h0, 1, 0, c);
        // Mid-run reset (R5)
        step(32'h0, 32'h0, 0, 0, 3, 0);
        // Random traffic
        for (int i = 0; i < 400; i++) begin
            bit [31:0] a = $urandom;
            bit [31:0] b = $urandom;
            if ($urandom % 4 == 0) b = a;
            if ($urandom % 8 == 0) a = 32'h80000000;
            step(a, b, int'($urandom % 4), 1'($urandom % 2), int'($urandom % 8),
                 ($urandom % 50) != 0);
        end
        step(32'h0, 32'h0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule